// File: doc/BRIEF.md
# Wake-Pin Event and Interrupt Routing Controller

This block watches a small set of external wake pins and three always-on peripheral interrupt lines (real-time clock, infrared receiver, watchdog). Each wake pin is resynchronized, then judged against its own trigger mode: a level (low or high), an edge (falling, rising or either), or no trigger. A matching event latches a per-pin status bit. Software masks the status bits with an enable register and acknowledges them through a write-one-to-clear register.

A single route register decides, for every source on its own, whether it reaches the normal interrupt outputs and whether it may raise the system wake request. All pins share one interrupt output. Each peripheral line has its own gated output. Software reaches the registers through a plain single-cycle port: a write takes effect at the clock edge where `reg_we` is high, and reads are combinational from `reg_addr`. The port has no back-pressure, so it has no valid/ready pair. Software is expected to zero the enable register before it programs routing.

Top module: `wakepin_ctrl`

## Requirements
- R1: After reset every pin's trigger mode reads 4 (no trigger). The status, enable and route registers read zero, and `pin_irq_o`, `per_irq_o` and `wake_o` are low.
- R2: With a level mode, the pin's status bit (bit n of the status register at 0x310) is set while the synchronized pin holds the active level. Mode code 0 means low is active and code 1 means high is active.
- R3: With an edge mode, a transition of the synchronized pin sets the status bit. Code 2 reacts to a falling transition, code 3 to a rising one and code 6 to either. A pin change made before clock edge a shows in status after edge a+2.
- R4: Mode 4 and the unassigned codes 5 and 7 never set a status bit.
- R5: Writing 1 to bit n at 0x318 clears status bit n, and writing 0 leaves it alone. This register reads zero. In a level mode, a pin still at its active level sets the bit again one cycle after the clear. In an edge mode, an edge arriving in the same cycle as the clear leaves the bit set.
- R6: `pin_irq_o` is high exactly when status, enable (0x314) and route bits 11:8 share a set bit for some pin n (bits n, n and 8+n).
- R7: `per_irq_o[k]` equals `per_irq_i[k]` AND route bit k, where k=0 is the real-time clock, k=1 is infrared and k=2 is the watchdog.
- R8: `wake_o` is the OR of (status bit n AND route bit 24+n) over all pins and (`per_irq_i[k]` AND route bit 16+k) over the three peripherals. The enable register has no effect on it.
- R9: The control register of pin n at 0x330+8n reads the synchronized pin level in bit 0, two edges after a pin change. Bits 3:1 read the mode, and bit 4 is a stored flag. The config word at 0x334+8n stores all 32 bits.
- R10: Writing a pin's control register reloads that pin's previous-level register, so a level change that happened while the pin was not in an edge mode does not appear as an edge.
- R11: The route register keeps only bits 27:24, 18:16, 11:8 and 2:0, and the enable register keeps only bits 3:0. A write of all ones reads back as 0x0F070F07 and 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, effective at the next clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| wake_pin_i | input | 4 | Raw external wake pins |
| per_irq_i | input | 3 | Peripheral interrupts: RTC, infrared, watchdog |
| pin_irq_o | output | 1 | Shared pin interrupt |
| per_irq_o | output | 3 | Routed peripheral interrupts |
| wake_o | output | 1 | System wake request |

## Verification
A pin change driven between edges reaches the synchronized level after two edges and the status bit after the third. A register write lands at the edge where its strobe is high, and the gated outputs follow that same edge combinationally. The bench drives on the falling edge. It reads status only after these counted edges: once just before the expected edge and once just after it, for latency, re-arm and clear-collision cases. The full mode sweep waits four cycles so that every pin has settled before it reads.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NPER = 3;

  typedef enum logic [2:0] {
    TRG_LOW  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_FALL = 3'd2,
    TRG_RISE = 3'd3,
    TRG_NONE = 3'd4,
    TRG_ANY  = 3'd6
  } trig_e;

  localparam logic [11:0] OFF_STATUS = 12'h310;
  localparam logic [11:0] OFF_ENABLE = 12'h314;
  localparam logic [11:0] OFF_CLEAR  = 12'h318;
  localparam logic [11:0] OFF_ROUTE  = 12'h31C;
  localparam logic [11:0] OFF_CTL    = 12'h330;
  localparam logic [11:0] OFF_CFG    = 12'h334;
  localparam int unsigned PIN_STRIDE = 8;

  localparam int unsigned RT_PIN_IRQ  = 8;
  localparam int unsigned RT_PIN_WAKE = 24;
  localparam int unsigned RT_PER_IRQ  = 0;
  localparam int unsigned RT_PER_WAKE = 16;

  function automatic logic trig_is_edge(input logic [2:0] m);
    return (m == TRG_FALL) || (m == TRG_RISE) || (m == TRG_ANY);
  endfunction
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/wpc_pin_det.sv
module wpc_pin_det
  import wpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  input  logic       reload_i,
  input  logic       clr_i,
  output logic       stat_o
);
  logic prev_q;
  logic stat_q;
  logic hit;
  logic edge_mode;

  assign edge_mode = trig_is_edge(mode_i);

  always_comb begin
    unique case (mode_i)
      TRG_LOW:  hit = ~lvl_i;
      TRG_HIGH: hit = lvl_i;
      TRG_FALL: hit = prev_q & ~lvl_i;
      TRG_RISE: hit = ~prev_q & lvl_i;
      TRG_ANY:  hit = prev_q ^ lvl_i;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (reload_i || edge_mode) prev_q <= lvl_i;
      if (edge_mode) stat_q <= hit | (stat_q & ~clr_i);
      else if (clr_i) stat_q <= 1'b0;
      else stat_q <= stat_q | hit;
    end
  end

  assign stat_o = stat_q;

  AST_NO_TRIGGER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRG_NONE && !stat_q) |=> !stat_q); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && hit && clr_i) |=> stat_q); // R5
  AST_LEVEL_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && clr_i) |=> !stat_q); // R5
endmodule

// File: rtl/wakepin_ctrl.sv
module wakepin_ctrl
  import wpc_pkg::*;
#(
  parameter int unsigned NPIN = 4,
  parameter int unsigned AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] wake_pin_i,
  input  logic [NPER-1:0] per_irq_i,
  output logic            pin_irq_o,
  output logic [NPER-1:0] per_irq_o,
  output logic            wake_o
);
  localparam logic [DW-1:0] PIN_BITS   = DW'((64'd1 << NPIN) - 64'd1);
  localparam logic [DW-1:0] PER_BITS   = DW'((64'd1 << NPER) - 64'd1);
  localparam logic [DW-1:0] ROUTE_MASK = (PIN_BITS << RT_PIN_IRQ) | (PIN_BITS << RT_PIN_WAKE)
                                       | (PER_BITS << RT_PER_IRQ) | (PER_BITS << RT_PER_WAKE);

  logic [NPIN-1:0] lvl;
  logic [NPIN-1:0] stat;
  logic [NPIN-1:0] en_q;
  logic [DW-1:0]   route_q;
  logic [NPIN-1:0] clr_vec;
  logic [NPIN-1:0] ctl_wr;
  logic [NPIN-1:0] cfg_wr;
  logic [2:0]      mode_q  [NPIN];
  logic            flag_q  [NPIN];
  logic [DW-1:0]   cfg_q   [NPIN];

  wpc_sync #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (wake_pin_i),
    .q_o  (lvl)
  );

  assign clr_vec = (reg_we && reg_addr == AW'(OFF_CLEAR)) ? reg_wdata[NPIN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == AW'(OFF_ENABLE)) en_q <= reg_wdata[NPIN-1:0];
      if (reg_addr == AW'(OFF_ROUTE))  route_q <= reg_wdata & ROUTE_MASK;
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    assign ctl_wr[n] = reg_we && (reg_addr == AW'(OFF_CTL + PIN_STRIDE * n));
    assign cfg_wr[n] = reg_we && (reg_addr == AW'(OFF_CFG + PIN_STRIDE * n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[n] <= TRG_NONE;
        flag_q[n] <= 1'b0;
        cfg_q[n]  <= '0;
      end else begin
        if (ctl_wr[n]) begin
          mode_q[n] <= reg_wdata[3:1];
          flag_q[n] <= reg_wdata[4];
        end
        if (cfg_wr[n]) cfg_q[n] <= reg_wdata;
      end
    end

    wpc_pin_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (lvl[n]),
      .mode_i  (mode_q[n]),
      .reload_i(ctl_wr[n]),
      .clr_i   (clr_vec[n]),
      .stat_o  (stat[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(OFF_STATUS))      reg_rdata = DW'(stat);
    else if (reg_addr == AW'(OFF_ENABLE)) reg_rdata = DW'(en_q);
    else if (reg_addr == AW'(OFF_ROUTE))  reg_rdata = route_q;
    for (int n = 0; n < NPIN; n++) begin
      if (reg_addr == AW'(OFF_CTL + PIN_STRIDE * n))
        reg_rdata = DW'({flag_q[n], mode_q[n], lvl[n]});
      if (reg_addr == AW'(OFF_CFG + PIN_STRIDE * n))
        reg_rdata = cfg_q[n];
    end
  end

  assign pin_irq_o = |(stat & en_q & route_q[RT_PIN_IRQ +: NPIN]);
  assign per_irq_o = per_irq_i & route_q[RT_PER_IRQ +: NPER];
  assign wake_o    = |(stat & route_q[RT_PIN_WAKE +: NPIN])
                   | |(per_irq_i & route_q[RT_PER_WAKE +: NPER]);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_irq_o |-> (en_q != '0)); // R6
  AST_PER_OUT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (per_irq_o & ~per_irq_i) == '0); // R7
  AST_WAKE_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ((route_q[RT_PIN_WAKE +: NPIN] != '0) || (route_q[RT_PER_WAKE +: NPER] != '0))); // R8
  AST_ROUTE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~ROUTE_MASK) == '0); // R11
endmodule

// File: tb/wakepin_ctrl_tb_top.sv
module wakepin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pins = '0;
  logic [2:0]  per_in = '0;
  logic        pin_irq;
  logic [2:0]  per_out;
  logic        wake;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wakepin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .wake_pin_i(pins), .per_irq_i(per_in),
    .pin_irq_o(pin_irq), .per_irq_o(per_out), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [11:0] ctl_a(input int n);
    return 12'h330 + 12'(8 * n);
  endfunction

  function automatic logic exp_hit(input int m, input logic v0, input logic v1);
    case (m)
      0: return !v0 || !v1;
      1: return v0 || v1;
      2: return v0 && !v1;
      3: return !v0 && v1;
      6: return v0 != v1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'h310, r); check("R1 status", r, 0);
    rd(12'h314, r); check("R1 enable", r, 0);
    rd(12'h31C, r); check("R1 route", r, 0);
    for (int n = 0; n < 4; n++) begin
      rd(ctl_a(n), r); check("R1 mode", {28'd0, r[3:1]}, 4);
    end
    check("R1 outputs", {29'd0, pin_irq, wake, |per_out}, 0);

    // R11 masking, R9 storage
    wr(12'h31C, 32'hFFFF_FFFF); rd(12'h31C, r); check("R11 route mask", r, 32'h0F07_0F07);
    wr(12'h314, 32'hFFFF_FFFF); rd(12'h314, r); check("R11 enable mask", r, 32'hF);
    wr(12'h31C, 0); wr(12'h314, 0);
    rd(12'h318, r); check("R5 clear reads zero", r, 0);
    for (int n = 0; n < 4; n++) begin
      wr(ctl_a(n) + 12'd4, 32'hA5C3_0000 + 32'(n));
      wr(ctl_a(n), 32'h18);
    end
    for (int n = 0; n < 4; n++) begin
      rd(ctl_a(n) + 12'd4, r); check("R9 cfg word", r, 32'hA5C3_0000 + 32'(n));
      rd(ctl_a(n), r); check("R9 flag and mode", {27'd0, r[4:1]}, 32'hC);
    end

    // R9 level bit latency: two edges
    @(negedge clk); pins[2] = 1'b1; addr = ctl_a(2);
    @(negedge clk); check("R9 level after one edge", {31'd0, rdata[0]}, 0);
    @(negedge clk); check("R9 level after two edges", {31'd0, rdata[0]}, 1);
    pins = '0; idle(4);

    // R2 R3 R4 sweep: every mode, pin and transition
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int t = 0; t < 4; t++) begin
          logic v0, v1;
          v0 = t[1]; v1 = t[0];
          @(negedge clk); pins[p] = v0;
          idle(4);
          wr(ctl_a(p), 32'(m) << 1);
          wr(12'h318, 32'hF);
          idle(1);
          @(negedge clk); pins[p] = v1;
          idle(4);
          rd(12'h310, r);
          if (m == 0 || m == 1)
            check("R2 level mode sweep", {31'd0, r[p]}, {31'd0, exp_hit(m, v0, v1)});
          else if (m == 2 || m == 3 || m == 6)
            check("R3 edge mode sweep", {31'd0, r[p]}, {31'd0, exp_hit(m, v0, v1)});
          else
            check("R4 no trigger sweep", {31'd0, r[p]}, 0);
        end
      end
      wr(ctl_a(p), 32'h8);
      pins[p] = 1'b0;
    end
    idle(4);
    wr(12'h318, 32'hF);

    // R3 latency: status after edge a+2
    wr(ctl_a(0), 32'h6);
    wr(12'h318, 32'hF);
    @(negedge clk); pins[0] = 1'b1; addr = 12'h310;
    @(negedge clk);
    @(negedge clk); check("R3 not yet at a+1", {31'd0, rdata[0]}, 0);
    @(negedge clk); check("R3 set after a+2", {31'd0, rdata[0]}, 1);

    // R5 edge collides with clear
    @(negedge clk); pins[0] = 1'b0; idle(4);
    wr(12'h318, 32'hF);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(12'h318, 32'h1);
    rd(12'h310, r); check("R5 edge beats clear", {31'd0, r[0]}, 1);
    wr(12'h318, 32'h0);
    rd(12'h310, r); check("R5 zero write keeps bit", {31'd0, r[0]}, 1);
    wr(12'h318, 32'h1);
    rd(12'h310, r); check("R5 clear edge bit", {31'd0, r[0]}, 0);

    // R5 level re-arm
    wr(ctl_a(0), 32'h2);
    idle(2);
    wr(12'h318, 32'h1);
    @(negedge clk); addr = 12'h310; #1;
    check("R5 level cleared", {31'd0, rdata[0]}, 0);
    @(negedge clk); #1;
    check("R5 level re-armed", {31'd0, rdata[0]}, 1);

    // R10 no false edge after mode change
    wr(ctl_a(1), 32'h8);
    @(negedge clk); pins[1] = 1'b0; idle(4);
    wr(ctl_a(1), 32'h8);
    @(negedge clk); pins[1] = 1'b1; idle(4);
    wr(ctl_a(1), 32'h6);
    wr(12'h318, 32'h0);
    idle(3);
    rd(12'h310, r); check("R10 no false rising edge", {31'd0, r[1]}, 0);
    pins = '0;
    for (int n = 0; n < 4; n++) wr(ctl_a(n), 32'h2);

    // R6 R8 sweep over status, enable, route
    for (int st = 0; st < 16; st++) begin
      @(negedge clk); pins = 4'(st);
      idle(4);
      wr(12'h318, 32'hF);
      idle(1);
      for (int en = 0; en < 16; en++) begin
        wr(12'h314, 32'(en));
        for (int rt = 0; rt < 16; rt++) begin
          wr(12'h31C, (32'(rt) << 8) | (32'(rt) << 24));
          check("R6 pin irq", {31'd0, pin_irq}, {31'd0, |(st & en & rt)});
          check("R8 wake from pins", {31'd0, wake}, {31'd0, |(st & rt)});
        end
      end
    end
    wr(12'h314, 0);
    @(negedge clk); pins = '0;
    for (int n = 0; n < 4; n++) wr(ctl_a(n), 32'h8);
    wr(12'h318, 32'hF);

    // R7 R8 peripheral sweep
    for (int pi = 0; pi < 8; pi++) begin
      for (int rt = 0; rt < 8; rt++) begin
        @(negedge clk); per_in = 3'(pi);
        wr(12'h31C, 32'(rt) | (32'(rt) << 16));
        check("R7 peripheral out", {29'd0, per_out}, 32'(pi & rt));
        check("R8 wake from peripherals", {31'd0, wake}, {31'd0, |(pi & rt)});
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule